// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal word address for a four-beat burst on a synchronous memory. A base address is captured when one of two address strobes is asserted and all three chip enables are active. After that, each cycle with the step input asserted moves the burst to its next beat. The upper address bits come straight from the captured base. Only the two low bits change, following a beat counter.

A static ordering input chooses how the counter combines with the two low base bits. In interleaved order the counter is XORed into them. In linear order it is added to them modulo four, with no carry into the upper bits.

A strobe that is accepted while a secondary enable is inactive deselects the block. This ends the burst, and later steps have no effect. The processor strobe is ignored completely while the master enable is inactive. All outputs are registered, except that the ordering input acts on the low address bits directly.

Top module: `bag_burst_addr`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `mem_addr` is 0, `load_pulse` and `adv_pulse` are 0, and no burst is active.
- R2: A clock edge with `ctl_strobe_n`=0, `master_en_n`=0, `sec_en`=1 and `sec_en_n`=0 captures `base_in`. In the following cycle `mem_addr` equals that base and `load_pulse` is 1 for exactly one cycle.
- R3: `cpu_strobe_n`=0 loads under the same enable condition as in R2. While `master_en_n`=1 it is ignored: no load, no deselect, and a step in that cycle still advances the burst.
- R4: An edge where a strobe is accepted but the enables do not all hold is a deselect. An accepted strobe is `ctl_strobe_n`=0, or `cpu_strobe_n`=0 with `master_en_n`=0. A deselect gives no load and ends the burst. Later steps leave `mem_addr` unchanged and keep `adv_pulse` at 0 until the next load.
- R5: During an active burst, an edge with `step_n`=0 and no accepted strobe increments the beat counter by one. `adv_pulse` is 1 in the following cycle.
- R6: An edge with `step_n`=1 and no accepted strobe holds the beat counter, so `mem_addr` keeps its value and `adv_pulse` is 0.
- R7: With `order_ilv`=1, `mem_addr[1:0]` = base[1:0] XOR beat count.
- R8: With `order_ilv`=0, `mem_addr[1:0]` = (base[1:0] + beat count) mod 4.
- R9: After the fourth beat the counter wraps to 0 and keeps cycling through the same four addresses.
- R10: A load in the same edge as an asserted step takes priority. The beat counter restarts at 0 and `adv_pulse` stays 0.
- R11: `mem_addr[17:2]` stays equal to base[17:2] for the whole burst, in both orders and across wraps.
- R12: `load_pulse` and `adv_pulse` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_in | input | 18 | Base address offered with a strobe |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, gated by the master enable |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| master_en_n | input | 1 | Master chip enable, active low |
| sec_en | input | 1 | Secondary chip enable, active high |
| sec_en_n | input | 1 | Secondary chip enable, active low |
| step_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| mem_addr | output | 18 | Current burst address |
| load_pulse | output | 1 | A base was captured at the last edge |
| adv_pulse | output | 1 | The burst advanced at the last edge |

## Verification
A load and a step can arrive in the same edge. The bench provokes this by asserting a qualified strobe while `step_n` is low in the middle of a running burst. The expected result is `load_pulse` high, `adv_pulse` low, and `mem_addr` equal to the new base, not base plus one.

The bench also sends the processor strobe with the master enable inactive while stepping. Here the step must win, because the strobe does not count.

A behavioural reference model tracks base, beat and active state and is compared with the outputs on every clock.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;

  // Combine base low bits with the beat count for the selected order.
  function automatic logic [1:0] beat_lo(input logic [1:0] base_lo,
                                         input logic [1:0] beat,
                                         input order_e     ord);
    if (ord == ORDER_INTERLEAVED) beat_lo = base_lo ^ beat;
    else                          beat_lo = base_lo + beat;
  endfunction
endpackage

// File: rtl/bag_strobe_qual.sv
module bag_strobe_qual (
  input  logic cpu_strobe_n,
  input  logic ctl_strobe_n,
  input  logic master_en_n,
  input  logic sec_en,
  input  logic sec_en_n,
  output logic do_load,
  output logic do_desel
);
  logic accepted;
  logic enables_ok;

  always_comb begin
    // processor strobe only counts while the master enable is active
    accepted   = ~ctl_strobe_n | (~cpu_strobe_n & ~master_en_n);
    enables_ok = ~master_en_n & sec_en & ~sec_en_n;
    do_load    = accepted & enables_ok;
    do_desel   = accepted & ~enables_ok;
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic              do_desel,
  input  logic              step_n,
  output logic [BEAT_W-1:0] beat,
  output logic              load_q,
  output logic              adv_q
);
  logic active;
  logic step_ok;

  assign step_ok = ~step_n & active & ~do_load & ~do_desel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat   <= '0;
      active <= 1'b0;
      load_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      load_q <= do_load;
      adv_q  <= step_ok;
      if (do_load) begin
        beat   <= '0;
        active <= 1'b1;
      end else if (do_desel) begin
        active <= 1'b0;
      end else if (step_ok) begin
        beat <= beat + 1'b1;  // wraps naturally modulo 2**BEAT_W
      end
    end
  end
endmodule

// File: rtl/bag_addr_compose.sv
module bag_addr_compose
  import bag_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base_q,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  order_e ord;
  assign ord = order_e'(order_ilv);

  generate
    if (BEAT_W == 2) begin : g_two_bit
      assign addr = {base_q[ADDR_W-1:BEAT_W], beat_lo(base_q[1:0], beat, ord)};
    end else begin : g_generic
      logic [BEAT_W-1:0] lo;
      always_comb begin
        if (ord == ORDER_INTERLEAVED) lo = base_q[BEAT_W-1:0] ^ beat;
        else                          lo = base_q[BEAT_W-1:0] + beat;
      end
      assign addr = {base_q[ADDR_W-1:BEAT_W], lo};
    end
  endgenerate

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = addr[ADDR_W-1:BEAT_W];
endmodule

// File: rtl/bag_burst_addr.sv
module bag_burst_addr #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              master_en_n,
  input  logic              sec_en,
  input  logic              sec_en_n,
  input  logic              step_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              load_pulse,
  output logic              adv_pulse
);
  logic              do_load, do_desel;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base_q;

  bag_strobe_qual u_qual (
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .master_en_n(master_en_n), .sec_en(sec_en), .sec_en_n(sec_en_n),
    .do_load(do_load), .do_desel(do_desel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (do_load) base_q <= base_in;
  end

  bag_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .do_load(do_load), .do_desel(do_desel),
    .step_n(step_n), .beat(beat), .load_q(load_pulse), .adv_q(adv_pulse)
  );

  bag_addr_compose #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_comp (
    .base_q(base_q), .beat(beat), .order_ilv(order_ilv), .addr(mem_addr)
  );
endmodule

// File: rtl/bag_burst_addr_chk.sv
module bag_burst_addr_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] base_in,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              master_en_n,
  input logic              sec_en,
  input logic              sec_en_n,
  input logic              step_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              load_pulse,
  input logic              adv_pulse
);
  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && !master_en_n && sec_en && !sec_en_n)
      |=> (load_pulse && mem_addr == $past(base_in)));

  // R3
  cpu_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en_n && ctl_strobe_n) |=> !load_pulse);

  // R6
  hold_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_n |=> !adv_pulse);

  // R11
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_strobe_n && (cpu_strobe_n || master_en_n))
      |=> (mem_addr[ADDR_W-1:BEAT_W] == $past(mem_addr[ADDR_W-1:BEAT_W])));

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_pulse, adv_pulse}));
endmodule

bind bag_burst_addr bag_burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/tb_bag_burst_addr.sv
`timescale 1ns/1ps
module tb_bag_burst_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] base_in = '0;
  logic        cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1;
  logic        master_en_n = 1'b1, sec_en = 1'b0, sec_en_n = 1'b1;
  logic        step_n = 1'b1, order_ilv = 1'b1;
  logic [17:0] mem_addr;
  logic        load_pulse, adv_pulse;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    checking = 1'b0;

  // reference model state
  int m_base = 0, m_beat = 0, m_act = 0, m_ld = 0, m_av = 0;

  always #2.5 clk = ~clk;

  bag_burst_addr dut (.*);

  always @(posedge clk) begin
    int acc, ok;
    acc = (!ctl_strobe_n) || (!cpu_strobe_n && !master_en_n);
    ok  = !master_en_n && sec_en && !sec_en_n;
    if (!rst_n) begin
      m_base = 0; m_beat = 0; m_act = 0; m_ld = 0; m_av = 0;
    end else if (acc && ok) begin
      m_base = base_in; m_beat = 0; m_act = 1; m_ld = 1; m_av = 0;
    end else if (acc) begin
      m_act = 0; m_ld = 0; m_av = 0;
    end else if (!step_n && m_act) begin
      m_beat = (m_beat + 1) % 4; m_ld = 0; m_av = 1;
    end else begin
      m_ld = 0; m_av = 0;
    end
  end

  function automatic int exp_addr();
    int lo;
    lo = order_ilv ? ((m_base & 3) ^ m_beat) : (((m_base & 3) + m_beat) % 4);
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (checking) begin
      check(cur_req, mem_addr, exp_addr());
      check(cur_req, load_pulse, m_ld);
      check(cur_req, adv_pulse, m_av);
      check("R12", int'(load_pulse && adv_pulse), 0);
    end
  end

  task automatic idle();
    cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ctl(int b, bit stp);
    @(negedge clk);
    base_in = b[17:0]; master_en_n = 0; sec_en = 1; sec_en_n = 0;
    ctl_strobe_n = 0; cpu_strobe_n = 1; step_n = stp ? 0 : 1;
    @(negedge clk);
    idle();
  endtask

  task automatic steps(int n);
    @(negedge clk);
    step_n = 0;
    cyc(n);
    step_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    checking = 1'b1;
    cyc(3);
    cur_req = "R1";
    check("R1", mem_addr, 0);
    check("R1", load_pulse, 0);
    @(negedge clk); rst_n = 1;

    cur_req = "R2"; order_ilv = 1;
    load_ctl(18'h2A5F3, 0);
    check("R2", mem_addr, 18'h2A5F3);
    cyc(2);

    cur_req = "R7"; steps(3);
    cur_req = "R6"; cyc(3);
    cur_req = "R9"; steps(6);

    cur_req = "R8"; order_ilv = 0;
    load_ctl(18'h3FFFE, 0);
    cur_req = "R11"; steps(3);
    check("R11", mem_addr, 18'h3FFFD);
    cur_req = "R9"; steps(5);

    cur_req = "R10";
    @(negedge clk); step_n = 0;
    load_ctl(18'h01235, 1);
    check("R10", mem_addr, 18'h01235);
    steps(2);

    cur_req = "R3";
    @(negedge clk);
    master_en_n = 1; cpu_strobe_n = 0; step_n = 0; base_in = 18'h3C000;
    cyc(3);
    idle();
    cyc(1);
    check("R3", load_pulse, 0);
    @(negedge clk);
    master_en_n = 0; sec_en = 1; sec_en_n = 0; cpu_strobe_n = 0; base_in = 18'h15556;
    @(negedge clk); idle();
    check("R3", mem_addr, 18'h15556);
    steps(2);

    cur_req = "R4"; order_ilv = 1;
    @(negedge clk);
    ctl_strobe_n = 0; sec_en = 0; base_in = 18'h00777;
    @(negedge clk); idle(); sec_en = 1;
    steps(4);
    check("R4", adv_pulse, 0);
    load_ctl(18'h20001, 0);
    @(negedge clk);
    cpu_strobe_n = 0; sec_en_n = 1;
    @(negedge clk); idle(); sec_en_n = 0;
    steps(3);

    cur_req = "R5";
    load_ctl(18'h1ABCD, 0);
    steps(2);
    cyc(2);

    checking = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule